// File: doc/BRIEF.md
# Temperature-Compensated Threshold Calculator

This block produces the threshold word that a PWM-based threshold generator turns into a discriminator level. Input receiver thresholds drift with temperature by roughly 0.1 mV per kelvin. The block corrects for this by adding an offset that is linear in the measured temperature and scaled by a programmable signed 16-bit coefficient.

A requester presents a base threshold, a temperature reading in sixteenths of a degree Celsius and the coefficient, then pulses `start_i` for one cycle. In degrees, the offset is temperature × coefficient / 256. In raw sixteenth-degree units, it is the signed product arithmetically shifted right by 12. The block adds the offset to the base and clamps the sum to the unsigned threshold range. The result appears two cycles later, together with a one-cycle `res_valid_o` pulse.

The block handles one channel per request. It is fully pipelined, so a new request may start on every cycle.

Top module: `thrcomp_top`

## Requirements
- R1: After synchronous reset, `res_valid_o` is 0 and `thr_o` is 0.
- R2: Each cycle with `start_i` high produces exactly one cycle of `res_valid_o` high, two clock edges later. Back-to-back starts give back-to-back valid pulses, in request order.
- R3: Temperature and coefficient are two's-complement signed. The result is base + ((temp × coef) >>> 12), where >>> is an arithmetic shift of the full 32-bit signed product and base is unsigned.
- R4: A coefficient of zero returns the base threshold unchanged, bit for bit, for any temperature.
- R5: A sum above 65535 is clamped to 65535 (16'hFFFF). It does not wrap.
- R6: A sum below 0 is clamped to 0. It does not wrap.
- R7: A negative offset rounds toward minus infinity. For example, temp = -1 with coef = 1 gives base - 1.
- R8: `thr_o` holds its last value on every cycle where `res_valid_o` is low.
- R9: Inputs are sampled only in the `start_i` cycle. Input changes while `start_i` is low create no result and do not alter `thr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, one cycle per channel |
| base_thr_i | input | 16 | Programmed base threshold, unsigned |
| temp_i | input | 16 | Temperature, signed, 1/16 °C per LSB |
| coef_i | input | 16 | Compensation coefficient, signed |
| thr_o | output | 16 | Compensated, saturated threshold |
| res_valid_o | output | 1 | One-cycle strobe marking a new `thr_o` |

## Verification
The bench builds the block with its default widths: a 16-bit threshold, temperature and coefficient, and a 12-bit shift. With these widths the shifted product spans about ±2^18. That range lets an ordinary base threshold cross both the 65535 and the 0 rails, so both saturation paths and the floor rounding of negative offsets can be reached directly. Randomised signed operands, back-to-back starts and idle cycles with changing inputs exercise ordering and hold behaviour against a scoreboard model.

// File: rtl/thrcomp_pkg.sv
package thrcomp_pkg;

    localparam int THR_W     = 16;
    localparam int TEMP_W    = 16;
    localparam int COEF_W    = 16;
    localparam int FRAC_BITS = 12;

    localparam int PROD_W = TEMP_W + COEF_W;
    localparam int SUM_W  = PROD_W + 2;

    typedef logic [THR_W-1:0]         thr_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    // Record passed from the multiply stage to the sum stage.
    typedef struct packed {
        logic  vld;
        thr_t  base;
        prod_t prod;
    } mul_rec_t;

    // Record held at the output.
    typedef struct packed {
        logic vld;
        thr_t thr;
    } out_rec_t;

    localparam sum_t THR_MAX = sum_t'({THR_W{1'b1}});

    // Clamp a signed wide sum onto the unsigned threshold range.
    function automatic thr_t clamp_thr(input sum_t s);
        thr_t r;
        if (s < 0)
            r = '0;
        else if (s > THR_MAX)
            r = {THR_W{1'b1}};
        else
            r = s[THR_W-1:0];
        return r;
    endfunction

    // Extend the shifted product to the sum width, keeping its sign.
    function automatic sum_t widen_off(input prod_t p);
        return {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/thrcomp_mul_stage.sv
module thrcomp_mul_stage
    import thrcomp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  thr_t                     base_i,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic signed [COEF_W-1:0] coef_i,
    output mul_rec_t                 rec_o
);
    prod_t    prod_c;
    mul_rec_t rec_q;

    always_comb begin
        prod_c = prod_t'(temp_i) * prod_t'(coef_i);
    end

    // Operands are captured only on a request cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q.vld <= start_i;
            if (start_i) begin
                rec_q.base <= base_i;
                rec_q.prod <= prod_c;
            end
        end
    end

    assign rec_o = rec_q;
endmodule

// File: rtl/thrcomp_sum_stage.sv
module thrcomp_sum_stage
    import thrcomp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mul_rec_t rec_i,
    output out_rec_t out_o
);
    prod_t    off_c;
    sum_t     sum_c;
    out_rec_t out_q;

    always_comb begin
        off_c = rec_i.prod >>> FRAC_BITS;
        sum_c = sum_t'({{(SUM_W-THR_W){1'b0}}, rec_i.base}) + widen_off(off_c);
    end

    // The threshold register loads only with a valid record and holds otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= rec_i.vld;
            if (rec_i.vld)
                out_q.thr <= clamp_thr(sum_c);
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/thrcomp_top.sv
module thrcomp_top
    import thrcomp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [THR_W-1:0]  base_thr_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [COEF_W-1:0] coef_i,
    output logic [THR_W-1:0]  thr_o,
    output logic              res_valid_o
);
    mul_rec_t mul_rec;
    out_rec_t out_rec;

    thrcomp_mul_stage u_mul (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .base_i  (base_thr_i),
        .temp_i  ($signed(temp_i)),
        .coef_i  ($signed(coef_i)),
        .rec_o   (mul_rec)
    );

    thrcomp_sum_stage u_sum (
        .clk   (clk),
        .rst   (rst),
        .rec_i (mul_rec),
        .out_o (out_rec)
    );

    assign thr_o       = out_rec.thr;
    assign res_valid_o = out_rec.vld;
endmodule

// File: rtl/thrcomp_chk.sv
module thrcomp_chk
    import thrcomp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [THR_W-1:0]  base_thr_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic [COEF_W-1:0] coef_i,
    input logic [THR_W-1:0]  thr_o,
    input logic              res_valid_o
);
    logic t_neg, c_neg, t_pos, c_pos;
    assign t_neg = temp_i[TEMP_W-1];
    assign c_neg = coef_i[COEF_W-1];
    assign t_pos = !t_neg && (temp_i != '0);
    assign c_pos = !c_neg && (coef_i != '0);

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ##2 res_valid_o);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(start_i, 2));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !res_valid_o |-> $stable(thr_o));

    assert_zero_coef_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i && coef_i == '0) |-> ##2 (thr_o == $past(base_thr_i, 2)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && base_thr_i == {THR_W{1'b1}} && !t_neg && !c_neg)
            |-> ##2 (thr_o == {THR_W{1'b1}}));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && base_thr_i == '0 && ((t_neg && c_pos) || (t_pos && c_neg)))
            |-> ##2 (thr_o == '0));
endmodule

bind thrcomp_top thrcomp_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .base_thr_i  (base_thr_i),
    .temp_i      (temp_i),
    .coef_i      (coef_i),
    .thr_o       (thr_o),
    .res_valid_o (res_valid_o)
);

// File: tb/sim_thrcomp_top.sv
`timescale 1ns/1ps
module sim_thrcomp_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        start_i = 0;
    logic [15:0] base_thr_i = 0;
    logic [15:0] temp_i = 0;
    logic [15:0] coef_i = 0;
    logic [15:0] thr_o;
    logic        res_valid_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] q_val[$];
    int          q_cyc[$];
    string       q_tag[$];
    logic [15:0] last_exp = 0;
    bit          done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    thrcomp_top u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .base_thr_i(base_thr_i),
        .temp_i(temp_i), .coef_i(coef_i), .thr_o(thr_o), .res_valid_o(res_valid_o)
    );

    function automatic logic [15:0] model(input logic [15:0] b, input logic [15:0] t,
                                          input logic [15:0] c);
        longint p, s;
        p = longint'($signed(t)) * longint'($signed(c));
        s = longint'(b) + (p >>> 12);
        if (s < 0) return 16'h0000;
        if (s > 65535) return 16'hFFFF;
        return s[15:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one request in the current cycle; start stays high until idle() lowers it.
    task automatic issue(input logic [15:0] b, input logic [15:0] t, input logic [15:0] c,
                         input string tag);
        base_thr_i = b; temp_i = t; coef_i = c; start_i = 1;
        q_val.push_back(model(b, t, c));
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Idle cycles with changing inputs and start low (R9).
    task automatic idle(input int n);
        start_i = 0;
        for (int i = 0; i < n; i++) begin
            base_thr_i = 16'($urandom); temp_i = 16'($urandom); coef_i = 16'($urandom);
            @(negedge clk);
        end
    endtask

    // Monitor: compares each result against the head of the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && res_valid_o) begin
                if (q_val.size() == 0) begin
                    check(0, "R2/R9 unexpected valid", 1, 0);
                end else begin
                    logic [15:0] e; int ec; string tg;
                    e = q_val.pop_front(); ec = q_cyc.pop_front(); tg = q_tag.pop_front();
                    check(cyc == ec, "R2 latency", cyc, ec);
                    check(thr_o == e, tg, thr_o, e);
                    last_exp = e;
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(res_valid_o == 0, "R1 valid after reset", res_valid_o, 0);
        check(thr_o == 0, "R1 thr after reset", thr_o, 0);

        issue(16'd1000, 16'd400, 16'd256, "R3 basic 25C");           // 1025
        issue(16'd5000, -16'sd160, 16'd1000, "R3/R7 negative temp");  // 4960
        issue(16'd300, 16'd800, -16'sd512, "R3 negative coef");       // 200
        idle(3);
        issue(16'd12345, 16'h7FFF, 16'd0, "R4 zero coef");
        issue(16'hBEEF, 16'h8000, 16'd0, "R4 zero coef min temp");
        idle(2);
        issue(16'd65000, 16'd2000, 16'd10000, "R5 high clamp");
        issue(16'hFFFF, 16'd1, 16'd1, "R5 clamp at max");
        idle(2);
        issue(16'd100, -16'sd2000, 16'd5000, "R6 low clamp");
        issue(16'd0, 16'd1, -16'sd1, "R6/R7 zero base floor");
        idle(2);
        issue(16'd500, -16'sd1, 16'd1, "R7 floor -1");                // 499
        issue(16'd500, 16'd1, 16'd1, "R7 small positive");            // 500
        idle(3);

        // R9: inputs change right after the start cycle; the captured operands must be used.
        issue(16'd2000, 16'd160, 16'd512, "R9 sampled at start");     // 2020
        idle(6);
        check(q_val.size() == 0, "R2 queue drained", q_val.size(), 0);
        check(thr_o == last_exp, "R8/R9 hold after idle", thr_o, last_exp);

        for (int k = 0; k < 60; k++) begin
            issue(16'($urandom), 16'($urandom), 16'($urandom), "R3 random");
            if (k % 7 == 3) idle(1);
        end
        idle(8);
        check(q_val.size() == 0, "R2 all results seen", q_val.size(), 0);
        check(thr_o == last_exp, "R8 final hold", thr_o, last_exp);
        done = 1;
    end

    initial begin
        int w = 0;
        while (!done && w < 5000) begin
            @(posedge clk);
            w++;
        end
        if (!done) check(0, "watchdog", w, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule